// File: doc/BRIEF.md
# Thermal and Power Clock Governor

This block chooses the target frequency for an accelerator clock. Three things bound it: the frequency cap of the selected power mode, a temperature limit that falls linearly across a derate band, and a power limit driven by a moving average of power samples checked against the budget of the active mode. On every update tick the target register moves toward the lowest of these three bounds. It never moves by more than one 50 MHz step per tick. The target therefore ramps rather than jumps, both when a mode changes and when a limit changes.

A separate temperature guard latches a shutdown request once the junction reading reaches the critical level. Throttling never produces that request. The request stays set until reset. A throttling flag tells the system when the target sits below the cap of the active mode. Sensor links, PLL reprogramming and voltage control belong to other blocks.

Top module: `thermal_clock_governor`

## Requirements
- R1: After reset the target is 0 MHz, the shutdown request is low and the throttling flag is high. The target then climbs 50 MHz per tick toward its goal.
- R2: Mode code 0 caps the clock at 408 MHz with a 7.0 W budget, code 1 at 625 MHz with 15.0 W, code 2 at 1020 MHz with 25.0 W, and code 3 behaves as code 0. Power is in units of 0.1 W, so the budgets are 70, 150 and 250.
- R3: The temperature limit is 1020 MHz below 60 °C. From 60 °C up to 99 °C it is floor(1020*(100-T)/40) rounded down to a multiple of 50 MHz. At 100 °C and above it is 0.
- R4: The target changes only in a cycle that follows a tick. It moves toward min(mode cap, temperature limit, power limit) by min(50, distance) MHz.
- R5: The shutdown request rises one cycle after a clock edge that sees a temperature of 105 °C or more. It stays high until reset, and it never rises while the temperature stays below 105 °C.
- R6: Average power is the floor of the sum of the last 16 valid samples divided by 16, with the history starting at zero. On a tick where the average exceeds the budget, the power limit becomes min(power limit, target) - 50, saturating at 0.
- R7: On a tick where the average is at most 95 % of the budget (avg*20 <= budget*19), a run counter advances. On the 16th such tick in a row, the power limit rises by 50 MHz, up to 1020 MHz, and the run restarts. Any tick outside that margin clears the run. The power limit resets to 1020 MHz.
- R8: The throttling flag is high exactly when the target is below the cap of the mode currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Update strobe; one step decision per pulse |
| temp_c | input | 8 | Junction temperature, whole degrees Celsius |
| pwr_sample | input | 10 | Power sample in 0.1 W units |
| pwr_valid | input | 1 | Pushes pwr_sample into the averaging window |
| mode | input | 2 | Power mode code |
| clk_target_mhz | output | 11 | Target clock frequency in MHz |
| throttling | output | 1 | Target below the cap of the active mode |
| shutdown_req | output | 1 | Latched emergency shutdown request |

## Verification
A corrupted averaging window or run counter does not show at the ports at once. It shows some ticks later as a target that stops falling while power stays high, or that rises earlier or later than the sixteenth calm tick. A wrong step or goal value shows at the first tick after the fault, as a target that differs from an independent per-cycle model. A faulty shutdown latch shows on the cycle after the temperature falls back.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  localparam int FREQ_W   = 11;
  localparam int STEP_MHZ = 50;
  localparam int FMAX_MHZ = 1020;
  localparam int T_KNEE   = 60;
  localparam int T_ZERO   = 100;
  localparam int T_CRIT   = 105;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_MID  = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_RSVD = 2'd3
  } pmode_e;

  function automatic logic [FREQ_W-1:0] mode_cap(input logic [1:0] m);
    case (pmode_e'(m))
      MODE_MID:  return FREQ_W'(625);
      MODE_HIGH: return FREQ_W'(1020);
      default:   return FREQ_W'(408);
    endcase
  endfunction

  // budget in 0.1 W units
  function automatic logic [9:0] mode_budget(input logic [1:0] m);
    case (pmode_e'(m))
      MODE_MID:  return 10'd150;
      MODE_HIGH: return 10'd250;
      default:   return 10'd70;
    endcase
  endfunction

  function automatic logic [FREQ_W-1:0] temp_limit(input logic [7:0] t);
    int v;
    if (int'(t) < T_KNEE)  return FREQ_W'(FMAX_MHZ);
    if (int'(t) >= T_ZERO) return '0;
    v = (FMAX_MHZ * (T_ZERO - int'(t))) / (T_ZERO - T_KNEE);
    v = (v / STEP_MHZ) * STEP_MHZ;
    return FREQ_W'(v);
  endfunction

  function automatic logic [FREQ_W-1:0] min2(input logic [FREQ_W-1:0] a,
                                             input logic [FREQ_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [FREQ_W-1:0] step_down(input logic [FREQ_W-1:0] v);
    return (int'(v) >= STEP_MHZ) ? FREQ_W'(int'(v) - STEP_MHZ) : '0;
  endfunction

  function automatic logic [FREQ_W-1:0] step_up(input logic [FREQ_W-1:0] v);
    return (int'(v) + STEP_MHZ >= FMAX_MHZ) ? FREQ_W'(FMAX_MHZ)
                                            : FREQ_W'(int'(v) + STEP_MHZ);
  endfunction

  function automatic logic [FREQ_W-1:0] step_toward(input logic [FREQ_W-1:0] cur,
                                                    input logic [FREQ_W-1:0] goal);
    if (cur < goal)
      return (int'(goal) - int'(cur) > STEP_MHZ) ? FREQ_W'(int'(cur) + STEP_MHZ) : goal;
    if (cur > goal)
      return (int'(cur) - int'(goal) > STEP_MHZ) ? FREQ_W'(int'(cur) - STEP_MHZ) : goal;
    return cur;
  endfunction

  // true when avg <= 95 % of budget
  function automatic logic is_calm(input logic [9:0] avg, input logic [9:0] bud);
    return (int'(avg) * 20) <= (int'(bud) * 19);
  endfunction

endpackage

// File: rtl/tcg_pwr_avg.sv
module tcg_pwr_avg #(
  parameter int PWR_W    = 10,
  parameter int AVG_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PWR_W-1:0] sample,
  output logic [PWR_W-1:0] avg
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = PWR_W + AVG_LOG2;

  logic [PWR_W-1:0] hist [DEPTH];
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (push) begin
      sum_q <= sum_q + SUM_W'(sample) - SUM_W'(hist[DEPTH-1]);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist[i] <= '0;
      else if (push) hist[i] <= (i == 0) ? sample : hist[(i == 0) ? 0 : i-1];
    end
  end

  assign avg = PWR_W'(sum_q >> AVG_LOG2);

  // R6: the window changes only on a pushed sample
  assert_avg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(sum_q));

endmodule

// File: rtl/tcg_pwr_limit.sv
module tcg_pwr_limit
  import tcg_pkg::*;
#(
  parameter int PWR_W      = 10,
  parameter int RISE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PWR_W-1:0]  avg,
  input  logic [9:0]        budget,
  input  logic [FREQ_W-1:0] cur_target,
  output logic [FREQ_W-1:0] lim
);
  localparam int CNT_W = $clog2(RISE_TICKS + 1);

  logic [CNT_W-1:0] run_q;
  logic over_ev, calm_ev, rise_ev;

  assign over_ev = tick && (avg > PWR_W'(budget));
  assign calm_ev = tick && !over_ev && is_calm(10'(avg), budget);
  assign rise_ev = calm_ev && (int'(run_q) == RISE_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim   <= FREQ_W'(FMAX_MHZ);
      run_q <= '0;
    end else if (tick) begin
      if (over_ev) begin
        lim   <= step_down(min2(lim, cur_target));
        run_q <= '0;
      end else if (rise_ev) begin
        lim   <= step_up(lim);
        run_q <= '0;
      end else if (calm_ev) begin
        run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assert_lim_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lim <= FREQ_W'(FMAX_MHZ));
  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) < RISE_TICKS);
  assert_over_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    over_ev |=> (lim == '0) || (int'(lim) <= int'($past(lim)) - STEP_MHZ));
  assert_lim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lim));

endmodule

// File: rtl/tcg_temp_guard.sv
module tcg_temp_guard
  import tcg_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_c,
  output logic [FREQ_W-1:0] lim,
  output logic              sd
);
  logic crit_ev;

  assign crit_ev = int'(temp_c) >= T_CRIT;
  assign lim     = temp_limit(8'(temp_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sd <= 1'b0;
    else if (crit_ev) sd <= 1'b1;
  end

  assert_sd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd) |-> int'($past(temp_c)) >= T_CRIT);
  assert_sd_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sd |=> sd);
  assert_lim_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_c) >= T_KNEE) |-> (int'(lim) % STEP_MHZ == 0));

endmodule

// File: rtl/thermal_clock_governor.sv
module thermal_clock_governor
  import tcg_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int PWR_W      = 10,
  parameter int AVG_LOG2   = 4,
  parameter int RISE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [PWR_W-1:0]  pwr_sample,
  input  logic              pwr_valid,
  input  logic [1:0]        mode,
  output logic [FREQ_W-1:0] clk_target_mhz,
  output logic              throttling,
  output logic              shutdown_req
);
  logic [FREQ_W-1:0] cap_mhz, temp_lim, pwr_lim, goal_mhz, tgt_q;
  logic [PWR_W-1:0]  avg_pwr;
  logic              step_up_ev, step_dn_ev;

  tcg_pwr_avg #(.PWR_W(PWR_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .push(pwr_valid), .sample(pwr_sample), .avg(avg_pwr));

  tcg_pwr_limit #(.PWR_W(PWR_W), .RISE_TICKS(RISE_TICKS)) u_plim (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avg(avg_pwr),
    .budget(mode_budget(mode)), .cur_target(tgt_q), .lim(pwr_lim));

  tcg_temp_guard #(.TEMP_W(TEMP_W)) u_tguard (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .lim(temp_lim), .sd(shutdown_req));

  assign cap_mhz    = mode_cap(mode);
  assign goal_mhz   = min2(min2(cap_mhz, temp_lim), pwr_lim);
  assign step_up_ev = tick && (tgt_q < goal_mhz);
  assign step_dn_ev = tick && (tgt_q > goal_mhz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tgt_q <= '0;
    else if (step_up_ev || step_dn_ev) tgt_q <= step_toward(tgt_q, goal_mhz);
  end

  assign clk_target_mhz = tgt_q;
  assign throttling     = tgt_q < cap_mhz;

  assert_step_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(tgt_q) - int'($past(tgt_q)) <= STEP_MHZ) &&
             (int'($past(tgt_q)) - int'(tgt_q) <= STEP_MHZ));
  assert_tgt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tgt_q));
  assert_tgt_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_q <= FREQ_W'(FMAX_MHZ));
  assert_step_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn_ev |=> tgt_q < $past(tgt_q));

endmodule

// File: tb/thermal_clock_governor_bench.sv
module thermal_clock_governor_bench;
  logic clk = 0, rst_n = 0, tick = 0, pwr_valid = 0;
  logic [7:0] temp_c = 8'd40;
  logic [9:0] pwr_sample = 10'd40;
  logic [1:0] mode = 2'd2;
  logic [10:0] tgt;
  logic thr, sd;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  // reference model state
  int m_tgt, m_plim, m_run, m_qsum;
  bit m_sd;
  int q[$];

  always #2 clk = ~clk;

  thermal_clock_governor u_thermal_clock_governor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp_c(temp_c),
    .pwr_sample(pwr_sample), .pwr_valid(pwr_valid), .mode(mode),
    .clk_target_mhz(tgt), .throttling(thr), .shutdown_req(sd));

  function automatic int cap_of(int m);
    if (m == 1) return 625;
    if (m == 2) return 1020;
    return 408;
  endfunction
  function automatic int bud_of(int m);
    if (m == 1) return 150;
    if (m == 2) return 250;
    return 70;
  endfunction
  function automatic int tlim_of(int t);
    int best = 0;
    if (t < 60) return 1020;
    if (t >= 100) return 0;
    for (int k = 0; k <= 20; k++) if (2000 * k <= 1020 * (100 - t)) best = 50 * k;
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tgt = 0; m_plim = 1020; m_run = 0; m_sd = 0; m_qsum = 0;
      q.delete();
      for (int i = 0; i < 16; i++) q.push_back(0);
    end else begin
      int avg, goal, cur;
      started = 1;
      if (temp_c >= 105) m_sd = 1;
      if (tick) begin
        cur = m_tgt;
        avg = m_qsum / 16;
        goal = cap_of(mode);
        if (tlim_of(temp_c) < goal) goal = tlim_of(temp_c);
        if (m_plim < goal) goal = m_plim;
        if (m_tgt < goal) m_tgt = (goal - m_tgt > 50) ? m_tgt + 50 : goal;
        else if (m_tgt > goal) m_tgt = (m_tgt - goal > 50) ? m_tgt - 50 : goal;
        if (avg > bud_of(mode)) begin
          m_plim = (cur < m_plim ? cur : m_plim) - 50;
          if (m_plim < 0) m_plim = 0;
          m_run = 0;
        end else if (avg * 20 <= bud_of(mode) * 19) begin
          m_run++;
          if (m_run == 16) begin
            m_plim = (m_plim + 50 > 1020) ? 1020 : m_plim + 50;
            m_run = 0;
          end
        end else m_run = 0;
      end
      if (pwr_valid) begin
        q.push_back(pwr_sample);
        m_qsum += pwr_sample - q.pop_front();
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      chk("R4 target", tgt, m_tgt);
      chk("R8 throttling", thr, (m_tgt < cap_of(mode)) ? 1 : 0);
      chk("R5 shutdown", sd, m_sd);
    end
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_ticks(int n, int p);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1; pwr_valid = 1; pwr_sample = 10'(p);
      @(posedge clk); #1; tick = 0; pwr_valid = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    int held;
    idle(3);
    @(negedge clk);
    chk("R1 reset target", tgt, 0);
    chk("R1 reset throttle", thr, 1);
    chk("R1 reset shutdown", sd, 0);
    rst_n = 1;
    run_ticks(1, 40);
    @(negedge clk); chk("R1 first step", tgt, 50);
    run_ticks(24, 40);
    @(negedge clk); chk("R2 mode2 cap", tgt, 1020); chk("R8 at cap", thr, 0);
    held = tgt;
    idle(5);
    @(negedge clk); chk("R4 hold without tick", tgt, held);
    mode = 2'd1; run_ticks(12, 40);
    @(negedge clk); chk("R2 mode1 cap", tgt, 625);
    mode = 2'd0; run_ticks(6, 40);
    @(negedge clk); chk("R2 mode0 cap", tgt, 408);
    mode = 2'd3; run_ticks(3, 40);
    @(negedge clk); chk("R2 mode3 cap", tgt, 408);
    mode = 2'd2; temp_c = 8'd80; run_ticks(25, 40);
    @(negedge clk); chk("R3 80C limit", tgt, 500); chk("R8 derated", thr, 1);
    temp_c = 8'd61; run_ticks(12, 40);
    @(negedge clk); chk("R3 61C limit", tgt, 950);
    temp_c = 8'd99; run_ticks(25, 40);
    @(negedge clk); chk("R3 99C limit", tgt, 0);
    temp_c = 8'd100; run_ticks(2, 40);
    @(negedge clk); chk("R3 100C limit", tgt, 0); chk("R5 no sd at 100C", sd, 0);
    temp_c = 8'd59; run_ticks(25, 40);
    @(negedge clk); chk("R3 59C full", tgt, 1020);
    mode = 2'd0; run_ticks(15, 40);
    run_ticks(20, 90);
    @(negedge clk); chk("R6 stepped below cap", (tgt < 408) ? 1 : 0, 1);
    chk("R6 model", tgt, m_tgt);
    run_ticks(20, 30);
    @(negedge clk); chk("R7 partial recovery", tgt, m_tgt);
    run_ticks(200, 30);
    @(negedge clk); chk("R7 recovered", tgt, 408);
    temp_c = 8'd105; idle(1);
    @(negedge clk); chk("R5 sd raised", sd, 1);
    temp_c = 8'd20; idle(4);
    @(negedge clk); chk("R5 sd latched", sd, 1);
    rst_n = 0; idle(2);
    @(negedge clk); chk("R5 sd cleared by reset", sd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule